// File: doc/BRIEF.md
# Display Memory Write/Refresh Arbiter

This block owns one side of a small two-port display memory. On that side a processor writes display data, and it may read the data back. On the other side a refresh engine sweeps the memory without pause. The refresh side is a counter that presents one address per refresh slot and wraps at the top of the memory. Each slot returns the byte stored at that address on a registered data output.

A collision is when the processor has an access in progress and a refresh slot lands on the same address in the same cycle. The block shows a collision by driving an active-low busy flag. Busy holds back only processor writes: the write is not committed and its acknowledge is withheld until a cycle with no collision. The refresh read always goes ahead. It is never stalled, because one stale refresh pass is harmless on a display. Processor reads never wait for busy and finish in a fixed time.

The processor side is a level strobe/acknowledge handshake. The processor raises the strobe with its address, direction and data. It holds them until the acknowledge rises, then drops the strobe. The acknowledge falls on the next clock edge after that.

Top module: `disp_refresh_arb`

## Requirements
- R1: While reset is low and on the first cycle after it, `ref_addr` is 0, `cpu_ack` is 0, `ref_valid` is 0 and `busy_n` is 1.
- R2: Each clock edge with `ref_slot` high moves `ref_addr` up by one, and address 1023 goes to 0. An edge with `ref_slot` low leaves `ref_addr` unchanged.
- R3: `busy_n` is 0 exactly when three things hold in the same cycle: `ref_slot` is high, a processor access is pending (a write not yet committed, or a read in its issue cycle), and `cpu_addr` equals `ref_addr`.
- R4: In a cycle where a pending write sees `busy_n` at 0, the write is not committed and `cpu_ack` stays 0 on the next cycle.
- R5: A write is taken at the edge where an idle block sees the strobe high (`cpu_wr`=1). It commits at the first later edge where `busy_n` is 1. `cpu_ack` rises one edge after the commit. With no collision, `cpu_ack` is high after the second edge following acceptance.
- R6: A read (`cpu_wr`=0) taken at edge k sets `cpu_ack` high after edge k+1, with `cpu_rdata` equal to the byte stored at `cpu_addr`. This timing does not depend on `busy_n`.
- R7: After each edge with `ref_slot` high, `ref_valid` is 1 for one cycle and `ref_data` holds the byte stored at the address `ref_addr` had before that edge. This holds even when `busy_n` was 0. After an edge with `ref_slot` low, `ref_valid` is 0.
- R8: `cpu_ack` stays high while the strobe stays high. It falls on the first edge that sees the strobe low, and a new access is taken only after that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_strobe | input | 1 | Processor access request, held until acknowledged |
| cpu_wr | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 10 | Processor byte address |
| cpu_wdata | input | 8 | Processor write data |
| cpu_ack | output | 1 | Processor acknowledge |
| cpu_rdata | output | 8 | Processor read data, valid while acknowledged after a read |
| ref_slot | input | 1 | Refresh read slot this cycle |
| ref_addr | output | 10 | Current refresh address |
| ref_data | output | 8 | Byte returned by the last refresh slot |
| ref_valid | output | 1 | `ref_data` was updated by the previous edge |
| busy_n | output | 1 | Active-low same-address collision flag |

## Verification
The assertions assume the processor follows the handshake. Address, direction and write data must stay constant from the strobe rising until the acknowledge rises, and the strobe drops only after the acknowledge. The bench keeps to this by running every processor access through one task that changes these inputs only while the block is idle or acknowledging. To force collisions, the bench aims write addresses at the refresh address predicted for the wait cycle. Refresh slots are driven separately, as continuous, absent or random patterns.

// File: rtl/disp_refresh_arb.sv
module disp_refresh_arb #(
  parameter int AW = 10,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cpu_strobe,
  input  logic          cpu_wr,
  input  logic [AW-1:0] cpu_addr,
  input  logic [DW-1:0] cpu_wdata,
  output logic          cpu_ack,
  output logic [DW-1:0] cpu_rdata,
  input  logic          ref_slot,
  output logic [AW-1:0] ref_addr,
  output logic [DW-1:0] ref_data,
  output logic          ref_valid,
  output logic          busy_n
);
  localparam int DEPTH = 1 << AW;

  typedef enum logic [2:0] {IDLE, WR_WAIT, WR_DONE, RD_ISSUE, ACKED} ph_t;

  ph_t           ph;
  logic [DW-1:0] mem [DEPTH];
  logic          cpu_active;
  logic          wr_go;

  assign cpu_active = (ph == WR_WAIT) || (ph == RD_ISSUE);
  assign busy_n     = !(ref_slot && cpu_active && (cpu_addr == ref_addr));
  assign wr_go      = (ph == WR_WAIT) && busy_n;
  assign cpu_ack    = (ph == ACKED);

  always_ff @(posedge clk) begin
    if (wr_go) mem[cpu_addr] <= cpu_wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph <= IDLE;
    end else begin
      case (ph)
        IDLE:     if (cpu_strobe) ph <= cpu_wr ? WR_WAIT : RD_ISSUE;
        WR_WAIT:  if (busy_n) ph <= WR_DONE;
        WR_DONE:  ph <= ACKED;
        RD_ISSUE: ph <= ACKED;
        ACKED:    if (!cpu_strobe) ph <= IDLE;
        default:  ph <= IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ref_addr  <= '0;
      ref_data  <= '0;
      ref_valid <= 1'b0;
      cpu_rdata <= '0;
    end else begin
      ref_valid <= ref_slot;
      if (ref_slot) begin
        ref_data <= mem[ref_addr];
        ref_addr <= ref_addr + 1'b1;
      end
      if (ph == RD_ISSUE) cpu_rdata <= mem[cpu_addr];
    end
  end

  // R2
  ref_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ref_slot |=> ref_addr == $past(ref_addr) + 1'b1);
  // R2
  ref_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ref_slot |=> $stable(ref_addr));
  // R3
  busy_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_n |-> ref_slot && cpu_strobe && cpu_addr == ref_addr);
  // R4
  hold_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == WR_WAIT && !busy_n) |=> (ph == WR_WAIT) && !cpu_ack);
  // R6
  read_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == RD_ISSUE) |=> cpu_ack);
  // R7
  ref_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ref_slot |=> ref_valid);
  // R8
  ack_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_ack && cpu_strobe) |=> cpu_ack);
  // R8
  ack_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_ack && !cpu_strobe) |=> !cpu_ack);
endmodule

// File: tb/sim_disp_refresh_arb.sv
module sim_disp_refresh_arb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cpu_strobe = 1'b0, cpu_wr = 1'b0, ref_slot = 1'b0;
  logic [9:0] cpu_addr = '0;
  logic [7:0] cpu_wdata = '0;
  logic cpu_ack, ref_valid, busy_n;
  logic [7:0] cpu_rdata, ref_data;
  logic [9:0] ref_addr;

  always #2.5 clk = ~clk;

  disp_refresh_arb u0 (.clk(clk), .rst_n(rst_n), .cpu_strobe(cpu_strobe), .cpu_wr(cpu_wr),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_ack(cpu_ack), .cpu_rdata(cpu_rdata),
    .ref_slot(ref_slot), .ref_addr(ref_addr), .ref_data(ref_data), .ref_valid(ref_valid),
    .busy_n(busy_n));

  int tests = 0, fails = 0, cycles = 0;
  int slot_mode = 0;
  bit done = 0;

  // reference model: 0 idle, 1 write waiting, 2 write committed, 3 acked, 4 read issue
  int mphase = 0;
  int mref = 0;
  int mrefdata = 0;
  bit mvalid = 0, mrefknown = 0, mrdknown = 0;
  int mrdata = 0;
  int mem_m [1024];
  bit known [1024];
  bit last_was_read = 0;

  function automatic bit exp_busy();
    return ref_slot && (mphase == 1 || mphase == 4) && (int'(cpu_addr) == mref);
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (!rst_n) begin
      mphase = 0; mref = 0; mvalid = 0; mrefknown = 0;
    end else begin
      bit b;
      b = exp_busy();
      mvalid = ref_slot;
      if (ref_slot) begin
        mrefdata = mem_m[mref]; mrefknown = known[mref];
        mref = (mref + 1) % 1024;
      end
      case (mphase)
        0: if (cpu_strobe) mphase = cpu_wr ? 1 : 4;
        1: if (!b) begin mem_m[cpu_addr] = cpu_wdata; known[cpu_addr] = 1; mphase = 2; end
        2: mphase = 3;
        3: if (!cpu_strobe) mphase = 0;
        4: begin mrdata = mem_m[cpu_addr]; mrdknown = known[cpu_addr]; last_was_read = 1; mphase = 3; end
        default: mphase = 0;
      endcase
      if (mphase == 1) last_was_read = 0;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  always @(negedge clk) begin
    #1;
    if (!done && rst_n) begin
      chk("R3 busy_n", busy_n, !exp_busy());
      chk("R2 ref_addr", ref_addr, mref);
      chk("R7 ref_valid", ref_valid, mvalid);
      if (mvalid && mrefknown) chk("R7 ref_data", ref_data, mrefdata);
      chk(mphase == 1 ? "R4 ack held" : "R5 ack", cpu_ack, mphase == 3);
      if (mphase == 3 && last_was_read && mrdknown) chk("R6 rdata", cpu_rdata, mrdata);
    end
  end

  always @(posedge clk) begin
    if (cycles > 150000 && !done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog actual=%0d expected=<150000 cycles", cycles);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    forever begin
      @(negedge clk);
      case (slot_mode)
        0: ref_slot = 1'b0;
        1: ref_slot = 1'b1;
        default: ref_slot = ($urandom_range(0, 2) != 0);
      endcase
    end
  end

  task automatic access(input bit wr, input int addr, input int data);
    @(negedge clk);
    cpu_wr = wr; cpu_addr = addr[9:0]; cpu_wdata = data[7:0]; cpu_strobe = 1'b1;
    do @(negedge clk); while (!cpu_ack);
    repeat ($urandom_range(0, 2)) @(negedge clk);
    cpu_strobe = 1'b0;
    do @(negedge clk); while (cpu_ack);
  endtask

  initial begin
    foreach (known[i]) begin known[i] = 0; mem_m[i] = 0; end
    repeat (3) @(negedge clk);
    #1;
    chk("R1 reset ref_addr", ref_addr, 0);
    chk("R1 reset ack", cpu_ack, 0);
    chk("R1 reset busy_n", busy_n, 1);
    chk("R1 reset ref_valid", ref_valid, 0);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R1 after reset ref_addr", ref_addr, 0);
    chk("R1 after reset ack", cpu_ack, 0);
    // fill memory without refresh traffic
    for (int a = 0; a < 1024; a++) access(1, a, (a * 7 + 3) & 255);
    // read back some locations
    for (int a = 0; a < 40; a++) access(0, $urandom_range(0, 1023), 0);
    // continuous refresh over a full wrap
    slot_mode = 1;
    repeat (1100) @(negedge clk);
    // aimed collisions: address equals refresh address during the wait cycle
    for (int k = 0; k < 60; k++) begin
      @(negedge clk); #1;
      access(1, (mref + 2) % 1024, k);
      access(0, (mref + 1) % 1024, 0);
    end
    // random refresh with mixed traffic near the refresh pointer
    slot_mode = 2;
    for (int k = 0; k < 400; k++) begin
      access($urandom_range(0, 1), (mref + $urandom_range(0, 3)) % 1024, $urandom_range(0, 255));
    end
    slot_mode = 0;
    repeat (5) @(negedge clk);
    #1;
    chk("R2 hold without slots", ref_addr, mref);
    chk("R8 idle ack low", cpu_ack, 0);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule